// File: doc/BRIEF.md
# Line-Change Timestamp Engine

The engine watches a bank of asynchronous input lines and, for every line that software has enabled, turns each change of level (rising or falling) into a record holding the line index, the new level and a snapshot of a free-running 64-bit system counter. Records go into an internal 256-entry FIFO that software drains through a small register interface. Per-line enables are kept as 32-bit slices, and the number of slices is the parameter `NUM_SLICES`, with 3, 11 and 17 as the intended settings (96, 352 and 544 lines).

Each line passes through a two-flop synchroniser and is compared against the last level it reported. Lines that change in the same cycle each capture the same counter value and are queued one per cycle, lowest index first. A level interrupt stays high while FIFO occupancy is at or above a programmable threshold. A record that finds the FIFO full is dropped and a sticky overflow flag is set.

Register map (word addresses on `reg_addr_i`): 0x00 threshold, 0x01 status, 0x02 pop, 0x03 held timestamp bits 31:0, 0x04 held timestamp bits 63:32, 0x20 + s enable slice s (bit b enables line 32*s + b).

Top module: `line_stamp_engine`

## Requirements
- R1: After reset the FIFO is empty, the threshold reads 1, every enable slice reads 0, the overflow flag and `irq_o` are 0, and the status word reads 0.
- R2: A change in either direction on an enabled line yields one record. A pop read (address 0x02) returns bit 31 = 1 (valid), bit 30 = the new line level, and bits 15:0 = the line index.
- R3: The record's timestamp equals the `sys_cnt_i` value sampled on the third rising clock edge after the line changes. The pop read loads it into a holding register, read back at 0x03 (low word) and 0x04 (high word).
- R4: Changes on a line whose enable bit is 0 produce no record. Enabling the line later produces no record for the change made while it was disabled.
- R5: When several enabled lines change in the same cycle, they enter the FIFO in ascending index order, and all of them carry the same timestamp.
- R6: A write to the threshold register (0x00) stores the value clamped to 1..256, so 0 becomes 1 and anything above 256 becomes 256. `irq_o` and status bit 17 are 1 exactly when occupancy is greater than or equal to the threshold, and they fall as soon as occupancy drops below it.
- R7: A record that arrives while the FIFO holds 256 entries, with no pop in the same cycle, is discarded and sets status bit 16 (overflow). The flag stays set until a status write has bit 16 = 1; a status write with bit 16 = 0 leaves it set.
- R8: A record that arrives in the same cycle as a pop of a full FIFO is stored, occupancy stays 256, and the overflow flag is not set.
- R9: A pop read of an empty FIFO returns 0 and changes neither the occupancy nor the held timestamp.
- R10: Status bits 8:0 report the FIFO occupancy (0..256). The FIFO holds 256 records and returns them in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 32*NUM_SLICES | Monitored lines, asynchronous |
| sys_cnt_i | input | TS_W | Free-running system counter value |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe; a read of 0x02 pops on the clock edge |
| reg_addr_i | input | 8 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | 1 | Level interrupt: occupancy at or above threshold |

## Verification
The hardest case is a new record being written into the FIFO in the same cycle that software pops it. This matters most when the FIFO is full, because then the write slot and the read slot are the same entry. The bench fills the FIFO to 256 records and clears the overflow flag. It then toggles four lines together and issues a pop on each of the four edges on which their records are written. It expects the four oldest records to be returned, occupancy to stay at 256, the overflow flag to stay clear, and the four new records to drain afterwards in index order with their shared timestamp.

// File: rtl/lse_pkg.sv
package lse_pkg;
  localparam int unsigned REG_AW = 8;
  localparam logic [REG_AW-1:0] A_CFG     = 8'h00;
  localparam logic [REG_AW-1:0] A_STAT    = 8'h01;
  localparam logic [REG_AW-1:0] A_POP     = 8'h02;
  localparam logic [REG_AW-1:0] A_TS_LO   = 8'h03;
  localparam logic [REG_AW-1:0] A_TS_HI   = 8'h04;
  localparam logic [REG_AW-1:0] A_EN_BASE = 8'h20;
  localparam int unsigned STAT_OVF_BIT = 16;
  localparam int unsigned STAT_IRQ_BIT = 17;
  localparam int unsigned POP_VLD_BIT  = 31;
  localparam int unsigned POP_LVL_BIT  = 30;
endpackage

// File: rtl/lse_sync.sv
module lse_sync #(
  parameter int unsigned WIDTH = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/lse_capture.sv
module lse_capture #(
  parameter int unsigned NUM_LINES = 96,
  parameter int unsigned TS_W      = 64,
  parameter int unsigned IDX_W     = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [NUM_LINES-1:0] en_i,
  input  logic [TS_W-1:0]      sys_cnt_i,
  output logic                 evt_valid_o,
  output logic [IDX_W-1:0]     evt_idx_o,
  output logic                 evt_lvl_o,
  output logic [TS_W-1:0]      evt_ts_o
);
  logic [NUM_LINES-1:0] sync, prev_q, pend_q, lvl_q, fire, grant;
  logic [TS_W-1:0]      ts_q [NUM_LINES];
  logic [IDX_W-1:0]     sel;
  logic                 found;

  lse_sync #(.WIDTH(NUM_LINES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (lines_i),
    .sync_o  (sync)
  );

  // a queued line is not re-armed until its record has left
  assign fire = en_i & ~pend_q & (sync ^ prev_q);

  always_comb begin
    grant = '0;
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pend_q[i] && !found) begin
        found    = 1'b1;
        grant[i] = 1'b1;
        sel      = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
      lvl_q  <= '0;
    end else begin
      // disabled lines track so that enabling them later is silent
      prev_q <= (prev_q & en_i & ~fire) | (sync & (~en_i | fire));
      pend_q <= (pend_q & ~grant) | fire;
      lvl_q  <= (lvl_q & ~fire) | (sync & fire);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NUM_LINES; i++) begin
      if (fire[i]) ts_q[i] <= sys_cnt_i;
    end
  end

  assign evt_valid_o = found;
  assign evt_idx_o   = sel;
  assign evt_lvl_o   = lvl_q[sel];
  assign evt_ts_o    = ts_q[sel];
endmodule

// File: rtl/lse_fifo.sv
module lse_fifo #(
  parameter int unsigned DW    = 72,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          drop_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, pop_eff, wr;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign pop_eff = pop_i & ~empty_o;
  // full FIFO still accepts when the head leaves on the same edge
  assign wr      = push_i & (~full | pop_eff);
  assign drop_o  = push_i & ~wr;

  always_ff @(posedge clk_i) begin
    if (wr) mem[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr)      wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_eff) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(wr) - CW'(pop_eff);
    end
  end

  assign head_o  = mem[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/line_stamp_engine.sv
module line_stamp_engine
  import lse_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 3,
  parameter int unsigned TS_W       = 64,
  parameter int unsigned FIFO_DEPTH = 256
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [32*NUM_SLICES-1:0] lines_i,
  input  logic [TS_W-1:0]         sys_cnt_i,
  input  logic                    reg_we_i,
  input  logic                    reg_re_i,
  input  logic [REG_AW-1:0]       reg_addr_i,
  input  logic [31:0]             reg_wdata_i,
  output logic [31:0]             reg_rdata_o,
  output logic                    irq_o
);
  localparam int unsigned NUM_LINES = 32 * NUM_SLICES;
  localparam int unsigned IDX_W     = $clog2(NUM_LINES);
  localparam int unsigned REC_W     = 1 + IDX_W + TS_W;
  localparam int unsigned CW        = $clog2(FIFO_DEPTH) + 1;

  logic [NUM_LINES-1:0] en_q;
  logic [31:0]          en_slice [NUM_SLICES];
  logic [CW-1:0]        thr_q, fifo_cnt;
  logic                 ovf_q, fifo_empty, fifo_drop, pop_req;
  logic [63:0]          ts_hold_q;
  logic                 evt_valid, evt_lvl;
  logic [IDX_W-1:0]     evt_idx;
  logic [TS_W-1:0]      evt_ts;
  logic [REC_W-1:0]     head;
  logic [REG_AW-1:0]    slice_off;

  lse_capture #(
    .NUM_LINES (NUM_LINES),
    .TS_W      (TS_W),
    .IDX_W     (IDX_W)
  ) i_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lines_i     (lines_i),
    .en_i        (en_q),
    .sys_cnt_i   (sys_cnt_i),
    .evt_valid_o (evt_valid),
    .evt_idx_o   (evt_idx),
    .evt_lvl_o   (evt_lvl),
    .evt_ts_o    (evt_ts)
  );

  assign pop_req = reg_re_i && (reg_addr_i == A_POP);

  lse_fifo #(
    .DW    (REC_W),
    .DEPTH (FIFO_DEPTH)
  ) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (evt_valid),
    .push_data_i ({evt_lvl, evt_idx, evt_ts}),
    .pop_i       (pop_req),
    .head_o      (head),
    .count_o     (fifo_cnt),
    .empty_o     (fifo_empty),
    .drop_o      (fifo_drop)
  );

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[32*s +: 32] <= '0;
      end else if (reg_we_i && reg_addr_i == A_EN_BASE + REG_AW'(s)) begin
        en_q[32*s +: 32] <= reg_wdata_i;
      end
    end
    assign en_slice[s] = en_q[32*s +: 32];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= CW'(1);
    end else if (reg_we_i && reg_addr_i == A_CFG) begin
      if (reg_wdata_i == '0)                     thr_q <= CW'(1);
      else if (reg_wdata_i > 32'(FIFO_DEPTH))    thr_q <= CW'(FIFO_DEPTH);
      else                                       thr_q <= reg_wdata_i[CW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
    end else if (fifo_drop) begin
      ovf_q <= 1'b1;
    end else if (reg_we_i && reg_addr_i == A_STAT && reg_wdata_i[STAT_OVF_BIT]) begin
      ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_hold_q <= '0;
    end else if (pop_req && !fifo_empty) begin
      ts_hold_q <= 64'(head[TS_W-1:0]);
    end
  end

  assign irq_o     = (fifo_cnt >= thr_q);
  assign slice_off = reg_addr_i - A_EN_BASE;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CFG: reg_rdata_o[CW-1:0] = thr_q;
      A_STAT: begin
        reg_rdata_o[CW-1:0]         = fifo_cnt;
        reg_rdata_o[STAT_OVF_BIT]   = ovf_q;
        reg_rdata_o[STAT_IRQ_BIT]   = irq_o;
      end
      A_POP: begin
        if (!fifo_empty) begin
          reg_rdata_o[POP_VLD_BIT] = 1'b1;
          reg_rdata_o[POP_LVL_BIT] = head[REC_W-1];
          reg_rdata_o[IDX_W-1:0]   = head[TS_W +: IDX_W];
        end
      end
      A_TS_LO: reg_rdata_o = ts_hold_q[31:0];
      A_TS_HI: reg_rdata_o = ts_hold_q[63:32];
      default: begin
        if (reg_addr_i >= A_EN_BASE && slice_off < REG_AW'(NUM_SLICES))
          reg_rdata_o = en_slice[slice_off];
      end
    endcase
  end
endmodule

// File: rtl/line_stamp_engine_chk.sv
module line_stamp_engine_chk
  import lse_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic              clr_bit_i,
  input logic              irq_o,
  input logic [CW-1:0]     fifo_cnt,
  input logic [CW-1:0]     thr_q,
  input logic              ovf_q,
  input logic              push_v
);
  logic pop_req, ovf_clr;
  assign pop_req = reg_re_i && (reg_addr_i == A_POP);
  assign ovf_clr = reg_we_i && (reg_addr_i == A_STAT) && clr_bit_i;

  a_r6_thr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q >= CW'(1)) && (thr_q <= CW'(DEPTH)));

  a_r10_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  a_r10_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt != $past(fifo_cnt)) |->
      ((fifo_cnt == $past(fifo_cnt) + CW'(1)) || (fifo_cnt == $past(fifo_cnt) - CW'(1))));

  a_r6_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> (fifo_cnt < thr_q));

  a_r6_irq_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt >= thr_q) |-> irq_o);

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr) |=> ovf_q);

  a_r7_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_v && fifo_cnt == CW'(DEPTH) && !pop_req) |=> ovf_q);

  a_r8_full_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_v && fifo_cnt == CW'(DEPTH) && pop_req && !reg_we_i) |=>
      (fifo_cnt == CW'(DEPTH)) && (ovf_q == $past(ovf_q)));

  a_r9_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req && fifo_cnt == '0 && !push_v) |=> (fifo_cnt == '0));
endmodule

bind line_stamp_engine line_stamp_engine_chk #(.DEPTH(FIFO_DEPTH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_re_i   (reg_re_i),
  .reg_addr_i (reg_addr_i),
  .clr_bit_i  (reg_wdata_i[16]),
  .irq_o      (irq_o),
  .fifo_cnt   (fifo_cnt),
  .thr_q      (thr_q),
  .ovf_q      (ovf_q),
  .push_v     (evt_valid)
);

// File: tb/test_line_stamp_engine.sv
`timescale 1ns/1ps
module test_line_stamp_engine;
  localparam int NS = 3;
  localparam int NL = 32 * NS;
  localparam int DEPTH = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic [NL-1:0] cur_en = '0;
  logic [63:0]   sys_cnt = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_run = 0, n_fail = 0;
  int q_idx[$];
  bit q_lvl[$];
  logic [63:0] q_ts[$];

  line_stamp_engine i_line_stamp_engine (
    .clk_i (clk), .rst_ni (rst_n), .lines_i (lines), .sys_cnt_i (sys_cnt),
    .reg_we_i (we), .reg_re_i (re), .reg_addr_i (addr), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .irq_o (irq)
  );

  always #10 clk = ~clk;
  always @(negedge clk) sys_cnt <= sys_cnt + 64'd1;

  function automatic int exp_thr(input longint w);
    if (w == 0) return 1;
    if (w > DEPTH) return DEPTH;
    return int'(w);
  endfunction

  function automatic logic [31:0] exp_stat(input int cnt, input bit ovf, input int thr);
    logic [31:0] s = '0;
    s[8:0] = 9'(cnt);
    s[16]  = ovf;
    s[17]  = (cnt >= thr);
    return s;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1; #2; d = rdata;
    @(posedge clk); #1; re = 1'b0;
  endtask

  task automatic set_en(input int s, input logic [31:0] v);
    wr_reg(8'h20 + 8'(s), v);
    cur_en[32*s +: 32] = v;
  endtask

  task automatic apply(input logic [NL-1:0] nv, input bit nodrop, inout bit ovf);
    logic [63:0] v;
    @(negedge clk); #1;
    v = sys_cnt;
    for (int i = 0; i < NL; i++) begin
      if ((nv[i] ^ lines[i]) && cur_en[i]) begin
        if (q_idx.size() < DEPTH || nodrop) begin
          q_idx.push_back(i); q_lvl.push_back(nv[i]); q_ts.push_back(v + 64'd2);
        end else ovf = 1'b1;
      end
    end
    lines = nv;
  endtask

  task automatic settle();
    repeat (NL + 8) @(posedge clk);
    #1;
  endtask

  task automatic pop_word(input string req);
    logic [31:0] r;
    rd_reg(8'h02, r);
    if (q_idx.size() == 0) chk({req, " empty pop"}, r, 0);
    else begin
      chk({req, " valid"}, r[31], 1);
      chk({req, " level"}, r[30], q_lvl[0]);
      chk({req, " index"}, r[15:0], q_idx[0]);
      void'(q_idx.pop_front()); void'(q_lvl.pop_front()); void'(q_ts.pop_front());
    end
  endtask

  task automatic pop_full(input string req);
    logic [31:0] r, lo, hi;
    logic [63:0] ets;
    ets = q_ts[0];
    pop_word(req);
    rd_reg(8'h03, lo);
    rd_reg(8'h04, hi);
    chk({req, " R3 timestamp"}, {hi, lo}, ets);
  endtask

  task automatic drain(input string req);
    logic [31:0] r, lo0, lo1;
    while (q_idx.size() > 0) pop_full(req);
    rd_reg(8'h03, lo0);
    rd_reg(8'h02, r);
    chk("R9 empty pop returns zero", r, 0);
    rd_reg(8'h03, lo1);
    chk("R9 empty pop keeps held timestamp", lo1, lo0);
    rd_reg(8'h01, r);
    chk("R9 count stays zero", r[8:0], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bit ovf;
    int thr;
    logic [NL-1:0] nv;
    ovf = 1'b0;
    thr = 1;
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 reset state
    rd_reg(8'h01, r); chk("R1 status", r, 0);
    rd_reg(8'h00, r); chk("R1 threshold", r, 1);
    for (int s = 0; s < NS; s++) begin
      rd_reg(8'h20 + 8'(s), r); chk("R1 enable slice", r, 0);
    end
    chk("R1 irq", irq, 0);

    // R4 disabled lines are silent, also after enabling
    apply(96'h00F0_0000_0000_0000_0001_00FF, 0, ovf);
    settle();
    rd_reg(8'h01, r); chk("R4 no record while disabled", r[8:0], 0);
    for (int s = 0; s < NS; s++) set_en(s, 32'hFFFF_FFFF);
    settle();
    rd_reg(8'h01, r); chk("R4 no record after enabling", r[8:0], 0);

    // R2 R5 simultaneous edges, both directions
    nv = lines; nv[5] = ~nv[5]; nv[40] = ~nv[40]; nv[70] = ~nv[70]; nv[0] = ~nv[0];
    apply(nv, 0, ovf);
    settle();
    rd_reg(8'h01, r); chk("R10 count after four edges", r, exp_stat(4, 0, thr));
    chk("R6 irq with threshold 1", irq, 1);
    drain("R2 R5 ordered records");
    chk("R6 irq falls when empty", irq, 0);

    // R6 threshold clamp and level interrupt
    wr_reg(8'h00, 0);    rd_reg(8'h00, r); chk("R6 clamp zero", r, exp_thr(0));
    wr_reg(8'h00, 1000); rd_reg(8'h00, r); chk("R6 clamp high", r, exp_thr(1000));
    wr_reg(8'h00, 4);    rd_reg(8'h00, r); chk("R6 plain write", r, exp_thr(4));
    thr = 4;
    nv = lines; nv[1] = ~nv[1]; nv[2] = ~nv[2]; nv[3] = ~nv[3];
    apply(nv, 0, ovf); settle();
    chk("R6 irq below threshold", irq, 0);
    nv = lines; nv[90] = ~nv[90];
    apply(nv, 0, ovf); settle();
    chk("R6 irq at threshold", irq, 1);
    rd_reg(8'h01, r); chk("R6 status irq bit", r, exp_stat(4, 0, thr));
    pop_full("R6 pop");
    #1 chk("R6 irq falls below threshold", irq, 0);
    drain("R6 drain");

    // random batches
    for (int b = 0; b < 12; b++) begin
      logic [NL-1:0] m;
      for (int s = 0; s < NS; s++) set_en(s, $urandom);
      m = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      apply(lines ^ m, 0, ovf);
      settle();
      rd_reg(8'h01, r); chk("R10 random count", r[8:0], q_idx.size());
      drain("R2 R4 R5 random");
    end

    // R7 overflow
    for (int s = 0; s < NS; s++) set_en(s, 32'hFFFF_FFFF);
    wr_reg(8'h00, 256); thr = 256;
    for (int k = 0; k < 3; k++) begin
      apply(~lines, 0, ovf);
      settle();
    end
    rd_reg(8'h01, r); chk("R7 full with overflow", r, exp_stat(DEPTH, ovf, thr));
    wr_reg(8'h01, 32'h0000_0000);
    rd_reg(8'h01, r); chk("R7 write 0 keeps flag", r[16], 1);
    wr_reg(8'h01, 32'h0001_0000);
    rd_reg(8'h01, r); chk("R7 write 1 clears flag", r[16], 0);
    ovf = 1'b0;

    // R8 writes land while a full FIFO is popped
    apply(lines ^ 96'hF, 1, ovf);
    repeat (3) @(posedge clk);
    for (int k = 0; k < 4; k++) pop_word("R8 pop during write");
    settle();
    rd_reg(8'h01, r); chk("R8 full, no overflow", r, exp_stat(DEPTH, 0, thr));
    drain("R8 R10 full drain");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule